// File: doc/BRIEF.md
# Multi-Link Stream Controller

This block lets a processor exchange 32-bit words with up to eight outbound and eight inbound streaming links. Every link has a private FIFO. Each link talks to the outside world through a valid/ready handshake: a word moves in any cycle where both valid and ready are high. The host side is a small word-addressed register bus. Its lower half maps to one control/status word. Its upper half maps to eight data registers, one per link.

A write to a link's data register pushes the word into that link's outbound FIFO. A read from it pops the oldest word from that link's inbound FIFO. When the addressed FIFO cannot serve the access, the acknowledge is withheld, so the bus master stalls until space or data appears. The master may also withdraw the request, which abandons the access. The control word holds a global enable and the per-link FIFO status. It also holds read-only fields that describe the build parameters. Link counts (0 to 8 per direction) and power-of-two FIFO depths (1 to 32768 per direction) are parameters.

Top module: `stream_link_ctrl`

## Requirements
- R1: After reset the enable is clear, `bus_ack` is low, `bus_rdata` is zero, and every `tx_valid` and `rx_ready` bit is low.
- R2: `bus_addr` holds the word offset. Values 0 to 7 all read the same control word. Value 8+n selects link n. The control word has these bits: bit 31 is the enable and bit 30 is zero. Bits 29:26 hold log2 of the outbound depth and bits 25:22 hold log2 of the inbound depth. Bits 21:19 hold the outbound link count minus one and bits 18:16 hold the inbound link count minus one. Bit 8+n is set when outbound FIFO n can take a word. Bit n is set when inbound FIFO n holds a word.
- R3: A write to the control word loads the enable from `bus_wdata[31]` and ignores every other bit.
- R4: While enabled, a data write to an implemented link enqueues the word. Words leave on that link's `tx_data` in write order, one per cycle in which `tx_valid` and `tx_ready` are both high.
- R5: While enabled, `rx_ready` of an implemented link is high whenever its FIFO is not full. A data read returns the oldest word accepted on that link.
- R6: An access that can complete is acknowledged by a one-cycle `bus_ack` pulse in the cycle after the clock edge that samples the request. Read data is valid during that pulse. The master holds its request until the acknowledge.
- R7: A read of a link whose inbound FIFO is empty produces no acknowledge until a word arrives. It then completes with that word.
- R8: A write to a link whose outbound FIFO is full produces no acknowledge until a word drains. It then completes.
- R9: A data access to an unimplemented link acknowledges at once. A read returns zero and a write is discarded. Unimplemented links drive `tx_valid`, `tx_data` and `rx_ready` low.
- R10: While the enable is clear, all FIFOs are emptied and held empty, and `tx_valid` and `rx_ready` stay low. Data accesses acknowledge at once, with reads returning zero. After re-enabling, no flushed word reappears.
- R11: A stalled access whose request is withdrawn leaves no trace. No word is pushed or popped.
- R12: While `tx_valid` is high and `tx_ready` is low, `tx_valid` and `tx_data` of that link stay unchanged in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_req | input | 1 | Access request, held until acknowledge |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Word offset (0-7 control, 8+n link n) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with `bus_ack` |
| bus_ack | output | 1 | One-cycle access completion pulse |
| tx_data | output | 256 | Outbound data, link n in bits 32n+31:32n |
| tx_valid | output | 8 | Outbound valid per link |
| tx_ready | input | 8 | Outbound ready per link from the sink |
| rx_data | input | 256 | Inbound data, link n in bits 32n+31:32n |
| rx_valid | input | 8 | Inbound valid per link from the source |
| rx_ready | output | 8 | Inbound ready per link |

## Verification
The bench targets these corner cases, each named with the failure it would expose:
- Full and empty stalls. A design that acknowledged regardless would lose or invent words. The bench also releases a stall after several cycles to prove that the stalled access then completes.
- Withdrawn requests. A design that latched the pending access would push a phantom word or swallow an inbound one. The bench checks that the outbound word count and the inbound contents are unchanged.
- Unimplemented link addresses, where a wrong design hangs the bus forever.
- Disable with words still queued. Leftover words would stream out after re-enabling in a design that did not flush.
- Random writes under random sink back-pressure, which expose ordering and count errors in the FIFO pointers.

// File: rtl/slink_pkg.sv
package slink_pkg;
    localparam int MAX_LANES = 8;
    localparam int WORD_W    = 32;
    localparam int OFS_W     = 4;

    // control word layout
    localparam int CW_EN     = 31;
    localparam int CW_TXLOG  = 26;
    localparam int CW_RXLOG  = 22;
    localparam int CW_TXNUM  = 19;
    localparam int CW_RXNUM  = 16;
    localparam int CW_FREE   = 8;
    localparam int CW_AVAIL  = 0;

    typedef struct packed {
        logic              en;
        logic              ack;
        logic [WORD_W-1:0] rdata;
    } host_state_t;
endpackage

// File: rtl/stream_fifo.sv
module stream_fifo #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             not_full,
    output logic             not_empty
);
    localparam int PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW    = $clog2(DEPTH) + 1;
    localparam int SLOTS = 1 << PW;

    typedef struct packed {
        logic [PW-1:0] wr;
        logic [PW-1:0] rd;
        logic [CW-1:0] cnt;
    } fifo_state_t;

    fifo_state_t state_d, state_q;
    logic [WIDTH-1:0] mem_q [SLOTS];

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        state_d = state_q;
        if (flush) begin
            state_d = '0;
        end else begin
            if (push) state_d.wr = bump(state_q.wr);
            if (pop)  state_d.rd = bump(state_q.rd);
            state_d.cnt = state_q.cnt + CW'(push) - CW'(pop);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (push && !flush) mem_q[state_q.wr] <= push_data;
    end

    assign head      = mem_q[state_q.rd];
    assign not_full  = (state_q.cnt != CW'(DEPTH));
    assign not_empty = (state_q.cnt != '0);
endmodule

// File: rtl/tx_lane.sv
module tx_lane #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    output logic             free,
    output logic [WIDTH-1:0] tx_data,
    output logic             tx_valid,
    input  logic             tx_ready
);
    logic not_empty;
    logic pop;

    stream_fifo #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (!en),
        .push      (push),
        .push_data (push_data),
        .pop       (pop),
        .head      (tx_data),
        .not_full  (free),
        .not_empty (not_empty)
    );

    assign tx_valid = en && not_empty;
    assign pop      = tx_valid && tx_ready;
endmodule

// File: rtl/rx_lane.sv
module rx_lane #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             avail,
    input  logic [WIDTH-1:0] rx_data,
    input  logic             rx_valid,
    output logic             rx_ready
);
    logic not_full;
    logic push;

    stream_fifo #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (!en),
        .push      (push),
        .push_data (rx_data),
        .pop       (pop),
        .head      (head),
        .not_full  (not_full),
        .not_empty (avail)
    );

    assign rx_ready = en && not_full;
    assign push     = rx_valid && rx_ready;
endmodule

// File: rtl/stream_link_ctrl.sv
module stream_link_ctrl
    import slink_pkg::*;
#(
    parameter int NUM_TX   = 8,
    parameter int NUM_RX   = 8,
    parameter int TX_DEPTH = 4,
    parameter int RX_DEPTH = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          bus_req,
    input  logic                          bus_we,
    input  logic [OFS_W-1:0]              bus_addr,
    input  logic [WORD_W-1:0]             bus_wdata,
    output logic [WORD_W-1:0]             bus_rdata,
    output logic                          bus_ack,
    output logic [MAX_LANES*WORD_W-1:0]   tx_data,
    output logic [MAX_LANES-1:0]          tx_valid,
    input  logic [MAX_LANES-1:0]          tx_ready,
    input  logic [MAX_LANES*WORD_W-1:0]   rx_data,
    input  logic [MAX_LANES-1:0]          rx_valid,
    output logic [MAX_LANES-1:0]          rx_ready
);
    localparam logic [MAX_LANES-1:0] TX_IMPL = (NUM_TX == 0) ? '0 : MAX_LANES'((1 << NUM_TX) - 1);
    localparam logic [MAX_LANES-1:0] RX_IMPL = (NUM_RX == 0) ? '0 : MAX_LANES'((1 << NUM_RX) - 1);
    localparam logic [2:0] TX_NUM_F = (NUM_TX == 0) ? 3'd0 : 3'(NUM_TX - 1);
    localparam logic [2:0] RX_NUM_F = (NUM_RX == 0) ? 3'd0 : 3'(NUM_RX - 1);
    localparam logic [3:0] TX_LOG_F = 4'($clog2(TX_DEPTH));
    localparam logic [3:0] RX_LOG_F = 4'($clog2(RX_DEPTH));

    host_state_t st_d, st_q;

    logic                              en_q;
    logic [MAX_LANES-1:0]              tx_free;
    logic [MAX_LANES-1:0]              tx_push;
    logic [MAX_LANES-1:0]              rx_avail;
    logic [MAX_LANES-1:0]              rx_pop;
    logic [MAX_LANES-1:0][WORD_W-1:0]  rx_head;
    logic [WORD_W-1:0]                 status;
    logic                              sel_ctrl;
    logic [2:0]                        lane;

    assign en_q     = st_q.en;
    assign sel_ctrl = !bus_addr[OFS_W-1];
    assign lane     = bus_addr[2:0];

    // per-link lanes, tied off beyond the configured counts
    for (genvar i = 0; i < MAX_LANES; i++) begin : g_tx
        if (i < NUM_TX) begin : g_on
            tx_lane #(.WIDTH(WORD_W), .DEPTH(TX_DEPTH)) u_lane (
                .clk       (clk),
                .rst_n     (rst_n),
                .en        (en_q),
                .push      (tx_push[i]),
                .push_data (bus_wdata),
                .free      (tx_free[i]),
                .tx_data   (tx_data[i*WORD_W +: WORD_W]),
                .tx_valid  (tx_valid[i]),
                .tx_ready  (tx_ready[i])
            );
        end else begin : g_off
            logic unused_tx;
            assign unused_tx = tx_ready[i] ^ tx_push[i];
            assign tx_free[i]                  = 1'b0;
            assign tx_data[i*WORD_W +: WORD_W] = '0;
            assign tx_valid[i]                 = 1'b0;
        end
    end

    for (genvar i = 0; i < MAX_LANES; i++) begin : g_rx
        if (i < NUM_RX) begin : g_on
            rx_lane #(.WIDTH(WORD_W), .DEPTH(RX_DEPTH)) u_lane (
                .clk      (clk),
                .rst_n    (rst_n),
                .en       (en_q),
                .pop      (rx_pop[i]),
                .head     (rx_head[i]),
                .avail    (rx_avail[i]),
                .rx_data  (rx_data[i*WORD_W +: WORD_W]),
                .rx_valid (rx_valid[i]),
                .rx_ready (rx_ready[i])
            );
        end else begin : g_off
            logic unused_rx;
            assign unused_rx   = ^{rx_data[i*WORD_W +: WORD_W], rx_valid[i], rx_pop[i]};
            assign rx_head[i]  = '0;
            assign rx_avail[i] = 1'b0;
            assign rx_ready[i] = 1'b0;
        end
    end

    always_comb begin
        status                          = '0;
        status[CW_EN]                   = st_q.en;
        status[CW_TXLOG +: 4]           = TX_LOG_F;
        status[CW_RXLOG +: 4]           = RX_LOG_F;
        status[CW_TXNUM +: 3]           = TX_NUM_F;
        status[CW_RXNUM +: 3]           = RX_NUM_F;
        status[CW_FREE +: MAX_LANES]    = tx_free;
        status[CW_AVAIL +: MAX_LANES]   = rx_avail;
    end

    // host access sequencing
    always_comb begin
        st_d       = st_q;
        st_d.ack   = 1'b0;
        st_d.rdata = '0;
        tx_push    = '0;
        rx_pop     = '0;
        if (bus_req && !st_q.ack) begin
            if (sel_ctrl) begin
                st_d.ack = 1'b1;
                if (bus_we) st_d.en    = bus_wdata[CW_EN];
                else        st_d.rdata = status;
            end else if (bus_we) begin
                if (!st_q.en || !TX_IMPL[lane]) begin
                    st_d.ack = 1'b1;
                end else if (tx_free[lane]) begin
                    st_d.ack      = 1'b1;
                    tx_push[lane] = 1'b1;
                end
            end else begin
                if (!st_q.en || !RX_IMPL[lane]) begin
                    st_d.ack = 1'b1;
                end else if (rx_avail[lane]) begin
                    st_d.ack     = 1'b1;
                    rx_pop[lane] = 1'b1;
                    st_d.rdata   = rx_head[lane];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bus_ack   = st_q.ack;
    assign bus_rdata = st_q.rdata;
endmodule

module link_ctrl_chk #(
    parameter int NUM_TX = 8,
    parameter int NUM_RX = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         bus_req,
    input logic         bus_we,
    input logic [3:0]   bus_addr,
    input logic         bus_ack,
    input logic [255:0] tx_data,
    input logic [7:0]   tx_valid,
    input logic [7:0]   tx_ready,
    input logic [7:0]   rx_ready,
    input logic         en_q,
    input logic [7:0]   tx_free,
    input logic [7:0]   rx_avail
);
    AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack |=> !bus_ack); // R6

    AST_ACK_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack |-> $past(bus_req)); // R6

    AST_RD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_we && bus_addr[3] && en_q && (int'(bus_addr[2:0]) < NUM_RX)
         && !rx_avail[bus_addr[2:0]]) |=> !bus_ack); // R7

    AST_WR_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_we && bus_addr[3] && en_q && (int'(bus_addr[2:0]) < NUM_TX)
         && !tx_free[bus_addr[2:0]]) |=> !bus_ack); // R8

    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |-> (tx_valid == '0 && rx_ready == '0)); // R10

    for (genvar i = 0; i < 8; i++) begin : g_hold
        AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (tx_valid[i] && !tx_ready[i] && en_q) |=>
            (!en_q || (tx_valid[i] && $stable(tx_data[i*32 +: 32])))); // R12
    end
endmodule

bind stream_link_ctrl link_ctrl_chk #(.NUM_TX(NUM_TX), .NUM_RX(NUM_RX)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_req  (bus_req),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .bus_ack  (bus_ack),
    .tx_data  (tx_data),
    .tx_valid (tx_valid),
    .tx_ready (tx_ready),
    .rx_ready (rx_ready),
    .en_q     (en_q),
    .tx_free  (tx_free),
    .rx_avail (rx_avail)
);

// File: tb/tb_stream_link_ctrl.sv
module tb_stream_link_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int NTX = 3;
    localparam int NRX = 2;
    localparam int TXD = 4;
    localparam int RXD = 2;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         bus_req, bus_we;
    logic [3:0]   bus_addr;
    logic [31:0]  bus_wdata, bus_rdata;
    logic         bus_ack;
    logic [255:0] tx_data, rx_data;
    logic [7:0]   tx_valid, tx_ready, rx_valid, rx_ready;

    int n_checks = 0;
    int n_bad    = 0;

    logic [31:0] txm [NTX][256];
    int tx_wr [NTX];
    int tx_rd [NTX];

    stream_link_ctrl #(.NUM_TX(NTX), .NUM_RX(NRX), .TX_DEPTH(TXD), .RX_DEPTH(RXD)) dut (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_status(input bit en, input logic [7:0] free,
                                               input logic [7:0] avail);
        return {en, 1'b0, 4'($clog2(TXD)), 4'($clog2(RXD)), 3'(NTX-1), 3'(NRX-1), free, avail};
    endfunction

    // outbound sink monitor, sampled mid-cycle
    always @(negedge clk) begin
        if (rst_n) begin
            for (int l = 0; l < 8; l++) begin
                if (tx_valid[l] && tx_ready[l]) begin
                    if (l >= NTX) begin
                        chk(1'b0, "R9", "transfer on unimplemented link", 32'(l), 32'hFFFF_FFFF);
                    end else if (tx_rd[l] == tx_wr[l]) begin
                        chk(1'b0, "R4", "unexpected outbound word", tx_data[l*32 +: 32], 32'h0);
                    end else begin
                        chk(tx_data[l*32 +: 32] == txm[l][tx_rd[l] % 256], "R4", "outbound order",
                            tx_data[l*32 +: 32], txm[l][tx_rd[l] % 256]);
                        tx_rd[l]++;
                    end
                end
            end
        end
    end

    task automatic bus_do(input bit we, input logic [3:0] addr, input logic [31:0] wd,
                          input int max_wait, output bit acked, output logic [31:0] rd,
                          output int waited);
        bus_req = 1'b1; bus_we = we; bus_addr = addr; bus_wdata = wd;
        acked = 1'b0; rd = '0; waited = 0;
        for (int k = 0; k < max_wait; k++) begin
            @(posedge clk); #2;
            waited = k + 1;
            if (bus_ack) begin
                acked = 1'b1;
                rd = bus_rdata;
                break;
            end
        end
        bus_req = 1'b0; bus_we = 1'b0;
    endtask

    task automatic tx_write(input int l, input logic [31:0] d, input int max_wait, output bit acked);
        logic [31:0] rd;
        int w;
        txm[l][tx_wr[l] % 256] = d;
        tx_wr[l]++;
        bus_do(1'b1, 4'(8 + l), d, max_wait, acked, rd, w);
        if (!acked) tx_wr[l]--;
    endtask

    task automatic rx_send(input int l, input logic [31:0] d);
        rx_valid[l] = 1'b1;
        rx_data[l*32 +: 32] = d;
        while (1) begin
            @(negedge clk);
            if (rx_ready[l]) break;
        end
        @(posedge clk); #2;
        rx_valid[l] = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++; n_bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end

    initial begin
        bit          ok;
        logic [31:0] rd;
        int          w;
        logic [31:0] first;
        void'($urandom(32'd4242));
        for (int l = 0; l < NTX; l++) begin tx_wr[l] = 0; tx_rd[l] = 0; end
        rst_n = 1'b0; bus_req = 0; bus_we = 0; bus_addr = 0; bus_wdata = 0;
        tx_ready = 0; rx_valid = 0; rx_data = '0;
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;

        // R1 reset state
        chk(bus_ack == 1'b0, "R1", "ack after reset", 32'(bus_ack), 0);
        chk(bus_rdata == 0, "R1", "rdata after reset", bus_rdata, 0);
        chk(tx_valid == 0 && rx_ready == 0, "R1", "valid/ready after reset",
            {tx_valid, rx_ready}, 0);
        idle(1);

        // R2 / R6 control word, mirror
        bus_do(1'b0, 4'd0, 0, 5, ok, rd, w);
        chk(ok && w == 1, "R6", "ack latency", 32'(w), 1);
        chk(rd == exp_status(0, 8'h07, 8'h00), "R2", "status word", rd, exp_status(0, 8'h07, 8'h00));
        idle(1);
        bus_do(1'b0, 4'd5, 0, 5, ok, rd, w);
        chk(rd == exp_status(0, 8'h07, 8'h00), "R2", "mirror offset", rd, exp_status(0, 8'h07, 8'h00));

        // R10 accesses while disabled
        tx_ready = 8'hFF;
        bus_do(1'b1, 4'd8, 32'hDEAD_0001, 3, ok, rd, w);
        chk(ok, "R10", "disabled write acks", 32'(ok), 1);
        idle(3);
        chk(tx_valid == 0, "R10", "no output while disabled", 32'(tx_valid), 0);
        bus_do(1'b0, 4'd8, 0, 3, ok, rd, w);
        chk(ok && rd == 0, "R10", "disabled read zero", rd, 0);
        chk(rx_ready == 0, "R10", "rx_ready low while disabled", 32'(rx_ready), 0);
        tx_ready = 8'h00;

        // R3 enable with junk bits
        bus_do(1'b1, 4'd3, 32'h8000_1234, 3, ok, rd, w);
        bus_do(1'b0, 4'd0, 0, 5, ok, rd, w);
        chk(rd == exp_status(1, 8'h07, 8'h00), "R3", "enable only", rd, exp_status(1, 8'h07, 8'h00));
        chk(rx_ready[1:0] == 2'b11, "R5", "rx_ready when empty", 32'(rx_ready), 32'h3);
        chk(rx_ready[7:2] == 0, "R9", "unimplemented rx_ready", 32'(rx_ready), 32'h3);

        // R4 / R8 / R11 / R12 outbound stall on link 1
        for (int k = 0; k < TXD; k++) begin
            tx_write(1, 32'hA000_0000 + 32'(k), 5, ok);
            chk(ok, "R4", "fill write acks", 32'(ok), 1);
        end
        first = 32'hA000_0000;
        chk(tx_valid[1] && tx_data[63:32] == first, "R4", "head word", tx_data[63:32], first);
        bus_do(1'b0, 4'd0, 0, 5, ok, rd, w);
        chk(rd == exp_status(1, 8'h05, 8'h00), "R2", "free bits with full link", rd,
            exp_status(1, 8'h05, 8'h00));
        tx_write(1, 32'hBAD0_BAD0, 6, ok);
        chk(!ok, "R8", "full write stalls", 32'(ok), 0);
        idle(3);
        chk(tx_valid[1] && tx_data[63:32] == first, "R12", "held while not ready",
            tx_data[63:32], first);
        tx_ready[1] = 1'b1;
        idle(10);
        chk(tx_rd[1] == TXD && tx_valid[1] == 0, "R11", "abandoned write not sent",
            32'(tx_rd[1]), 32'(TXD));

        tx_ready[1] = 1'b0;
        for (int k = 0; k < TXD; k++) tx_write(1, 32'hB000_0000 + 32'(k), 5, ok);
        fork
            tx_write(1, 32'hB000_00FF, 30, ok);
            begin idle(5); tx_ready[1] = 1'b1; end
        join
        chk(ok, "R8", "stalled write completes", 32'(ok), 1);
        idle(10);
        chk(tx_rd[1] == tx_wr[1], "R4", "all words delivered", 32'(tx_rd[1]), 32'(tx_wr[1]));
        tx_ready = 8'h00;

        // R5 / R7 / R11 inbound
        rx_send(0, 32'h1111_0000);
        rx_send(0, 32'h2222_0000);
        chk(rx_ready[0] == 1'b0, "R5", "rx_ready drops when full", 32'(rx_ready[0]), 0);
        bus_do(1'b0, 4'd0, 0, 5, ok, rd, w);
        chk(rd == exp_status(1, 8'h07, 8'h01), "R2", "avail bit", rd, exp_status(1, 8'h07, 8'h01));
        bus_do(1'b0, 4'd8, 0, 5, ok, rd, w);
        chk(ok && rd == 32'h1111_0000, "R5", "first inbound word", rd, 32'h1111_0000);
        bus_do(1'b0, 4'd8, 0, 5, ok, rd, w);
        chk(ok && rd == 32'h2222_0000, "R5", "second inbound word", rd, 32'h2222_0000);
        bus_do(1'b0, 4'd9, 0, 5, ok, rd, w);
        chk(!ok, "R7", "empty read stalls", 32'(ok), 0);
        rx_send(1, 32'h3333_0000);
        bus_do(1'b0, 4'd9, 0, 5, ok, rd, w);
        chk(ok && rd == 32'h3333_0000, "R11", "abandoned read popped nothing", rd, 32'h3333_0000);
        bus_do(1'b0, 4'd9, 0, 4, ok, rd, w);
        chk(!ok, "R7", "drained link stalls again", 32'(ok), 0);
        fork
            bus_do(1'b0, 4'd8, 0, 30, ok, rd, w);
            begin idle(4); rx_send(0, 32'h4444_0000); end
        join
        chk(ok && rd == 32'h4444_0000, "R7", "stalled read completes", rd, 32'h4444_0000);

        // R9 unimplemented links
        tx_ready = 8'hFF;
        bus_do(1'b1, 4'd13, 32'h5555_5555, 3, ok, rd, w);
        chk(ok && w <= 2, "R9", "unimplemented write acks", 32'(w), 1);
        idle(3);
        chk(tx_valid == 0, "R9", "discarded write", 32'(tx_valid), 0);
        bus_do(1'b0, 4'd12, 0, 3, ok, rd, w);
        chk(ok && rd == 0, "R9", "unimplemented read zero", rd, 0);

        // R4 random traffic under random back-pressure
        for (int it = 0; it < 300; it++) begin
            int l;
            l = int'($urandom % NTX);
            tx_ready = 8'($urandom) | (8'h01 << l);
            tx_write(l, $urandom, 20, ok);
            chk(ok, "R4", "random write acks", 32'(ok), 1);
        end
        tx_ready = 8'hFF;
        idle(20);
        for (int l = 0; l < NTX; l++)
            chk(tx_rd[l] == tx_wr[l], "R4", "random traffic drained", 32'(tx_rd[l]), 32'(tx_wr[l]));

        // R10 flush on disable
        tx_ready = 8'h00;
        tx_write(2, 32'h6666_0001, 5, ok);
        tx_write(2, 32'h6666_0002, 5, ok);
        rx_send(1, 32'h7777_0000);
        bus_do(1'b1, 4'd0, 32'h0, 3, ok, rd, w);
        idle(3);
        chk(tx_valid == 0 && rx_ready == 0, "R10", "quiet when disabled", {tx_valid, rx_ready}, 0);
        bus_do(1'b0, 4'd0, 0, 5, ok, rd, w);
        chk(rd == exp_status(0, 8'h07, 8'h00), "R10", "flushed status", rd, exp_status(0, 8'h07, 8'h00));
        tx_rd[2] = tx_wr[2];
        bus_do(1'b1, 4'd0, 32'h8000_0000, 3, ok, rd, w);
        idle(2);
        chk(tx_valid == 0, "R10", "no stale outbound after re-enable", 32'(tx_valid), 0);
        bus_do(1'b0, 4'd9, 0, 3, ok, rd, w);
        chk(!ok, "R10", "no stale inbound after re-enable", 32'(ok), 0);
        tx_ready = 8'hFF;
        idle(3);

        $display("test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end
endmodule